// File: doc/BRIEF.md
# Bus Grant Responder

This block lets a processor that normally owns its external bus lend that bus to an outside requester. A mode input turns it on. When it is on, the block watches an active-low request line and answers on an active-low grant line. Before it grants, it waits for any external access already under way to finish, and for any indivisible read-modify-write sequence to end.

Once the grant is out, the block turns off the drivers for the address, data and control pins. It also stalls the core's own external accesses. When the requester drops its request, the grant is withdrawn. The processor takes its pins back only after the external bus-busy line is seen high, which means the borrower has let go.

Both external inputs are asynchronous to the core. Each passes through a synchronizer of `SYNC_STAGES` flops. The grant, drive-enable and stall outputs are decoded from one registered state, so all three move on the same clock edge.

Top module: `bus_grant_responder`

## Requirements
- R1: While rst_ni is low, grant_no is 1, pin_oe_o is 1 and stall_o is 0, whatever the other inputs are.
- R2: grant_oe_o follows slave_mode_i. While slave_mode_i is 0, grant_no is 1 from the next clock edge on and a request has no effect on any output.
- R3: In slave mode, with acc_busy_i and rmw_lock_i both low, a low level on ext_req_ni drives grant_no low on the (SYNC_STAGES+1)-th rising edge after the change.
- R4: No grant is issued on an edge where acc_busy_i is high. A grant may be issued on any single edge where acc_busy_i is low, even between two accesses of one multi-cycle instruction.
- R5: No grant is issued on an edge where rmw_lock_i is high.
- R6: Whenever grant_no is 0, pin_oe_o is 0, so the address, data and control pins are not driven.
- R7: Once ext_req_ni returns high, grant_no returns to 1 on the (SYNC_STAGES+1)-th rising edge.
- R8: After the grant is withdrawn, pin_oe_o stays 0 for as long as bus_busy_ni stays low. It returns to 1 on the (SYNC_STAGES+1)-th rising edge after bus_busy_ni goes high, and never while grant_no is 0.
- R9: stall_o is 1 for exactly the span in which pin_oe_o is 0, which runs from the grant until the bus is reclaimed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slave_mode_i | input | 1 | 1 enables the responder (grant pin is an output) |
| ext_req_ni | input | 1 | External bus request, active low, asynchronous |
| bus_busy_ni | input | 1 | External bus busy, active low, asynchronous |
| acc_busy_i | input | 1 | Core external access in progress |
| rmw_lock_i | input | 1 | Indivisible read-modify-write in progress |
| grant_no | output | 1 | Bus grant, active low |
| grant_oe_o | output | 1 | Output enable for the grant pin |
| pin_oe_o | output | 1 | Drive enable for address, data and control pins |
| stall_o | output | 1 | Holds off core external accesses while the bus is lent |

## Verification
The bench builds the block with the default SYNC_STAGES of 2. At that depth each input edge reaches the outputs on the third rising edge. The bench samples one edge early and one edge on time, so an extra or a missing synchronizer stage shows up as a timing error. With two stages, a request release and a bus-busy release that arrive together also finish within one settle window of the vector table. The directed tests hold bus-busy low well past that window, and they open an access gap of exactly one cycle.

// File: rtl/bgr_pkg.sv
package bgr_pkg;
  typedef enum logic [1:0] {
    ST_OWN     = 2'd0,
    ST_LENT    = 2'd1,
    ST_RECLAIM = 2'd2
  } bgr_state_e;
endpackage

// File: rtl/bgr_sync.sv
module bgr_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
    end else begin : g_chain
      logic [STAGES-1:0] ff_q;
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) ff_q[i] <= RST_VAL;
          else if (i == 0) ff_q[i] <= d_i;
          else ff_q[i] <= ff_q[(i == 0) ? 0 : i-1];
        end
      end
      assign q_o = ff_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/bgr_fsm.sv
module bgr_fsm
  import bgr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic req_i,
  input  logic busy_i,
  input  logic acc_busy_i,
  input  logic rmw_lock_i,
  output logic lent_o,
  output logic own_o
);
  bgr_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (!enable_i) begin
      state_d = ST_OWN;
    end else begin
      unique case (state_q)
        // grant only between accesses and outside indivisible sequences
        ST_OWN:     if (req_i && !acc_busy_i && !rmw_lock_i) state_d = ST_LENT;
        ST_LENT:    if (!req_i) state_d = ST_RECLAIM;
        ST_RECLAIM: if (!busy_i) state_d = ST_OWN;
        default:    state_d = ST_OWN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_OWN;
    else state_q <= state_d;
  end

  assign lent_o = (state_q == ST_LENT);
  assign own_o  = (state_q == ST_OWN);
endmodule

// File: rtl/bus_grant_responder.sv
module bus_grant_responder #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic slave_mode_i,
  input  logic ext_req_ni,
  input  logic bus_busy_ni,
  input  logic acc_busy_i,
  input  logic rmw_lock_i,
  output logic grant_no,
  output logic grant_oe_o,
  output logic pin_oe_o,
  output logic stall_o
);
  logic req_n_s, busy_n_s, lent, own;

  bgr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_req_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ext_req_ni), .q_o(req_n_s)
  );

  bgr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_busy_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(bus_busy_ni), .q_o(busy_n_s)
  );

  bgr_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .enable_i   (slave_mode_i),
    .req_i      (~req_n_s),
    .busy_i     (~busy_n_s),
    .acc_busy_i (acc_busy_i),
    .rmw_lock_i (rmw_lock_i),
    .lent_o     (lent),
    .own_o      (own)
  );

  assign grant_no   = ~lent;
  assign grant_oe_o = slave_mode_i;
  assign pin_oe_o   = own;
  assign stall_o    = ~own;
endmodule

// File: rtl/bgr_chk.sv
module bgr_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic slave_mode_i,
  input logic acc_busy_i,
  input logic rmw_lock_i,
  input logic grant_no,
  input logic pin_oe_o,
  input logic stall_o
);
  // R2
  master_no_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slave_mode_i |=> grant_no);

  // R4
  grant_after_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(grant_no) |-> !$past(acc_busy_i));

  // R5
  grant_not_in_rmw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(grant_no) |-> !$past(rmw_lock_i));

  // R6
  pins_off_when_lent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !grant_no |-> !pin_oe_o);

  // R8
  reclaim_after_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pin_oe_o) |-> $past(grant_no));

  // R9
  stall_while_lent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_oe_o |-> stall_o);
endmodule

bind bus_grant_responder bgr_chk u_bgr_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .slave_mode_i (slave_mode_i),
  .acc_busy_i   (acc_busy_i),
  .rmw_lock_i   (rmw_lock_i),
  .grant_no     (grant_no),
  .pin_oe_o     (pin_oe_o),
  .stall_o      (stall_o)
);

// File: tb/bus_grant_responder_bench.sv
module bus_grant_responder_bench;
  localparam int unsigned SYNC = 2;
  localparam int NVEC = 10;
  localparam int SETTLE = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic slave_mode_i = 1'b1, ext_req_ni = 1'b1, bus_busy_ni = 1'b1;
  logic acc_busy_i = 1'b0, rmw_lock_i = 1'b0;
  logic grant_no, grant_oe_o, pin_oe_o, stall_o;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  bus_grant_responder #(.SYNC_STAGES(SYNC)) u_bus_grant_responder (
    .clk_i(clk), .rst_ni(rst_ni), .slave_mode_i(slave_mode_i),
    .ext_req_ni(ext_req_ni), .bus_busy_ni(bus_busy_ni),
    .acc_busy_i(acc_busy_i), .rmw_lock_i(rmw_lock_i),
    .grant_no(grant_no), .grant_oe_o(grant_oe_o),
    .pin_oe_o(pin_oe_o), .stall_o(stall_o)
  );

  // {slave, req_n, busy_n, acc, rmw} -> {grant_oe, grant_n, pin_oe, stall}
  localparam logic [8:0] VEC [NVEC] = '{
    9'b11100_1110,  // idle, R2
    9'b10110_1110,  // request during access, R4
    9'b10101_1110,  // request during rmw, R5
    9'b10100_1001,  // grant, R3 R6 R9
    9'b10010_1001,  // lent, core wants bus, R9
    9'b11010_1101,  // released, busy low, R7 R8
    9'b11100_1110,  // busy high, reclaimed, R8
    9'b00100_0110,  // master mode ignores request, R2
    9'b10100_1001,  // slave again, grant, R3
    9'b11100_1110   // joint release, R7 R8
  };

  function automatic string vec_tag(int i);
    case (i)
      0, 7:    return "R2";
      1:       return "R4";
      2:       return "R5";
      3, 8:    return "R3";
      4:       return "R9";
      default: return "R8";
    endcase
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] outs();
    return {grant_oe_o, grant_no, pin_oe_o, stall_o};
  endfunction

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: outputs during reset, with a request pending
    ext_req_ni = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", outs(), 4'b1110);
    ext_req_ni = 1'b1;
    rst_ni = 1'b1;
    repeat (3) step();

    for (int i = 0; i < NVEC; i++) begin
      {slave_mode_i, ext_req_ni, bus_busy_ni, acc_busy_i, rmw_lock_i} = VEC[i][8:4];
      repeat (SETTLE) step();
      check(vec_tag(i), outs(), VEC[i][3:0]);
    end

    // R3: grant latency
    ext_req_ni = 1'b0;
    repeat (SYNC) step();
    check("R3", {3'b0, grant_no}, 4'b0001);
    step();
    check("R3", {3'b0, grant_no}, 4'b0000);

    // R7: release latency, borrower still busy
    bus_busy_ni = 1'b0;
    ext_req_ni = 1'b1;
    repeat (SYNC) step();
    check("R7", {3'b0, grant_no}, 4'b0000);
    step();
    check("R7", outs(), 4'b1101);

    // R8: long busy hold keeps pins off
    repeat (12) step();
    check("R8", outs(), 4'b1101);
    bus_busy_ni = 1'b1;
    repeat (SYNC) step();
    check("R8", {2'b0, pin_oe_o, stall_o}, 4'b0001);
    step();
    check("R9", outs(), 4'b1110);

    // R4: one-cycle gap between accesses admits the grant
    acc_busy_i = 1'b1;
    ext_req_ni = 1'b0;
    repeat (6) step();
    check("R4", outs(), 4'b1110);
    acc_busy_i = 1'b0;
    step();
    acc_busy_i = 1'b1;
    check("R4", outs(), 4'b1001);

    // R1: asynchronous reset while lent
    #2 rst_ni = 1'b0;
    #1 check("R1", outs(), 4'b1110);
    ext_req_ni = 1'b1;
    acc_busy_i = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) step();
    check("R1", outs(), 4'b1110);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule